// File: doc/BRIEF.md
# Aligned Bitmap Block Allocator

This block hands out and takes back space in a 16 KiB buffer memory. The memory is cut into equal blocks, and one bit per block records whether it is taken. The bits sit in a set of 32-bit map words. An allocate request carries a byte size and gets back a byte offset, or the value 16384 when it cannot be served. A free request carries an offset and a size, and the blocks it covers are marked unused again.

Requests use a single valid strobe and are taken only while the block is idle. The search rounds the request's block count up to a power of two and uses that as its stride. Every run therefore starts on a boundary of its own rounded size, and no run ever straddles two map words. One candidate position is tested per clock, so the time an allocation takes shows how far the search had to go. The block size is 16384 / (32 × MAP_WORDS): 256 bytes with the default two words, which caps one allocation at 8 KiB.

Top module: `blkmap_alloc`

## Requirements
- R1: A synchronous active-high reset clears every map bit and holds `busy` and `done` low; the first 256-byte allocation after reset returns offset 0.
- R2: An allocation occupies ceil(size / block size) blocks, and a successful result is the global block index × block size. The global block index is word × 32 + bit.
- R3: The stride is the smallest power of two from 1 to 32 that is at least the block count. Candidate bit positions inside a word are 0, stride, 2 × stride and so on, so every returned run starts on a multiple of its stride.
- R4: Candidates are tried in increasing bit order in word 0, then from bit 0 in word 1 and so on. The first free candidate wins.
- R5: A run is never placed across two map words. A 32-block request can only land on bit 0 of a fully free word.
- R6: A size of 0 returns 16384 and changes no map bit.
- R7: A size needing more than 32 blocks (more than 8192 bytes by default) returns 16384 and changes no map bit.
- R8: When no candidate in any word is free, the result is 16384 and no map bit changes.
- R9: A free computes the block count from its size the same way as an allocation. It clears that many bits starting at bit (offset / block size) mod 32 of word (offset / block size) / 32, and drops any bit beyond bit 31. A free completes with result 0.
- R10: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. `busy` is high from the next cycle until the cycle in which `done` pulses, which lasts one cycle with `busy` low. A `req_valid` while `busy` is high is ignored.
- R11: An allocation keeps `busy` high for one cycle per candidate tested (one cycle for a zero or oversize size). A free keeps it high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_free | input | 1 | 1 = free request, 0 = allocate request |
| req_size | input | SIZE_W | Byte size of the request |
| req_offset | input | SIZE_W | Byte offset to release (free only) |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| result_offset | output | SIZE_W | Allocated offset, 16384 on failure, 0 after a free |

## Verification
A directed sequence first fills words so that single-block, two-block, half-word and whole-word requests collide at chosen positions. This separates a wrong stride from a wrong block count, and a word-crossing placement from a correct move to the next word. Zero and just-oversize sizes tell the early refusal apart from an exhausted search, since each has its own cycle count. A free followed by a reallocation shows that exactly the released bits came back. A long stretch of mixed allocate and free requests is then compared clock by clock against a behavioural map model, which checks the latency as well as the offsets. A stray strobe raised during a search must leave no trace in later results.

// File: rtl/blkmap_pkg.sv
package blkmap_pkg;

   localparam int unsigned WORD_BITS = 32;
   localparam int unsigned POS_W     = 5;
   localparam int unsigned STEP_LG_W = 3;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_FREE = 2'd2
   } blk_state_e;

   // Run of `n` ones starting at bit 0, saturating at a full word.
   function automatic logic [WORD_BITS-1:0] run_ones(input logic [15:0] n);
      logic [WORD_BITS:0] wide;
      if (n >= 16'(WORD_BITS)) begin
         return '1;
      end
      wide = (33'd1 << n[5:0]) - 33'd1;
      return wide[WORD_BITS-1:0];
   endfunction

endpackage

// File: rtl/blkmap_sizer.sv
module blkmap_sizer
   import blkmap_pkg::*;
#(
   parameter int unsigned SIZE_W = 15,
   parameter int unsigned BLK_LG = 8
) (
   input  logic [SIZE_W-1:0]     size,
   output logic                  size_ok,
   output logic [STEP_LG_W-1:0]  step_lg,
   output logic [WORD_BITS-1:0]  run_mask
);
   localparam int unsigned SUM_W = SIZE_W + 1;
   localparam logic [SUM_W-1:0] ROUND = SUM_W'((1 << BLK_LG) - 1);

   logic [SUM_W-1:0] rounded;
   logic [SUM_W-1:0] blocks;

   always_comb begin
      rounded = {1'b0, size} + ROUND;
      blocks  = rounded >> BLK_LG;
      size_ok = (size != '0) && (blocks <= SUM_W'(WORD_BITS));
      step_lg = STEP_LG_W'(5);
      for (int k = 5; k >= 0; k--) begin
         if (blocks <= SUM_W'(1 << k)) begin
            step_lg = STEP_LG_W'(k);
         end
      end
      run_mask = run_ones(16'(blocks));
   end

endmodule

// File: rtl/blkmap_probe.sv
module blkmap_probe
   import blkmap_pkg::*;
(
   input  logic [WORD_BITS-1:0] map_word,
   input  logic [WORD_BITS-1:0] run_mask,
   input  logic [POS_W-1:0]     pos,
   input  logic [STEP_LG_W-1:0] step_lg,
   output logic [WORD_BITS-1:0] cand,
   output logic                 fits,
   output logic [POS_W-1:0]     next_pos,
   output logic                 wrap
);
   logic [POS_W:0] sum;

   always_comb begin
      cand     = run_mask << pos;
      fits     = (map_word & cand) == '0;
      sum      = {1'b0, pos} + ((POS_W+1)'(1) << step_lg);
      wrap     = sum[POS_W];
      next_pos = sum[POS_W-1:0];
   end

endmodule

// File: rtl/blkmap_words.sv
module blkmap_words
   import blkmap_pkg::*;
#(
   parameter int unsigned MAP_WORDS = 2,
   parameter int unsigned WIDX_W    = 1
) (
   input  logic                                clk,
   input  logic                                rst,
   input  logic                                set_en,
   input  logic [WIDX_W-1:0]                   set_sel,
   input  logic [WORD_BITS-1:0]                set_bits,
   input  logic                                clr_en,
   input  logic [WIDX_W-1:0]                   clr_sel,
   input  logic [WORD_BITS-1:0]                clr_bits,
   output logic [MAP_WORDS-1:0][WORD_BITS-1:0] words
);
   for (genvar g = 0; g < MAP_WORDS; g++) begin : g_word
      logic [WORD_BITS-1:0] word_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            word_q <= '0;
         end else if (set_en && set_sel == WIDX_W'(g)) begin
            word_q <= word_q | set_bits;
         end else if (clr_en && clr_sel == WIDX_W'(g)) begin
            word_q <= word_q & ~clr_bits;
         end
      end
      assign words[g] = word_q;
   end

endmodule

// File: rtl/blkmap_alloc.sv
module blkmap_alloc
   import blkmap_pkg::*;
#(
   parameter int unsigned MEM_BYTES = 16384,
   parameter int unsigned MAP_WORDS = 2,
   parameter int unsigned SIZE_W    = $clog2(MEM_BYTES) + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_free,
   input  logic [SIZE_W-1:0] req_size,
   input  logic [SIZE_W-1:0] req_offset,
   output logic              busy,
   output logic              done,
   output logic [SIZE_W-1:0] result_offset
);
   localparam int unsigned BLK    = MEM_BYTES / (WORD_BITS * MAP_WORDS);
   localparam int unsigned BLK_LG = $clog2(BLK);
   localparam int unsigned WIDX_W = (MAP_WORDS > 1) ? $clog2(MAP_WORDS) : 1;
   localparam int unsigned IDX_W  = SIZE_W - BLK_LG;
   localparam int unsigned HI_W   = IDX_W - POS_W;
   localparam logic [SIZE_W-1:0] FAIL_CODE = SIZE_W'(MEM_BYTES);
   localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(MAP_WORDS - 1);

   if (MEM_BYTES != (1 << $clog2(MEM_BYTES))) begin : g_chk_mem
      $error("MEM_BYTES must be a power of two");
   end
   if (MAP_WORDS != (1 << $clog2(MAP_WORDS)) || MAP_WORDS > 8) begin : g_chk_words
      $error("MAP_WORDS must be 1, 2, 4 or 8");
   end
   if (SIZE_W <= $clog2(MEM_BYTES)) begin : g_chk_width
      $error("SIZE_W too narrow to carry the failure code");
   end

   blk_state_e             state_q;
   logic [WIDX_W-1:0]      widx_q;
   logic [POS_W-1:0]       pos_q;
   logic [STEP_LG_W-1:0]   step_q;
   logic [WORD_BITS-1:0]   mask_q;
   logic                   bad_q;
   logic [WIDX_W-1:0]      clr_word_q;
   logic [WORD_BITS-1:0]   clr_bits_q;
   logic                   clr_ok_q;

   logic                   sz_ok;
   logic [STEP_LG_W-1:0]   sz_step;
   logic [WORD_BITS-1:0]   sz_mask;

   logic [MAP_WORDS-1:0][WORD_BITS-1:0] map_words;
   logic [WORD_BITS-1:0]   cur_word;
   logic [WORD_BITS-1:0]   cand;
   logic                   fits;
   logic [POS_W-1:0]       next_pos;
   logic                   wrap;
   logic                   place;

   logic [IDX_W-1:0]       free_idx;
   logic [HI_W-1:0]        free_hi;

   blkmap_sizer #(
      .SIZE_W (SIZE_W),
      .BLK_LG (BLK_LG)
   ) u_sizer (
      .size     (req_size),
      .size_ok  (sz_ok),
      .step_lg  (sz_step),
      .run_mask (sz_mask)
   );

   assign cur_word = map_words[widx_q];

   blkmap_probe u_probe (
      .map_word (cur_word),
      .run_mask (mask_q),
      .pos      (pos_q),
      .step_lg  (step_q),
      .cand     (cand),
      .fits     (fits),
      .next_pos (next_pos),
      .wrap     (wrap)
   );

   assign place = (state_q == ST_SCAN) && !bad_q && fits;

   blkmap_words #(
      .MAP_WORDS (MAP_WORDS),
      .WIDX_W    (WIDX_W)
   ) u_words (
      .clk      (clk),
      .rst      (rst),
      .set_en   (place),
      .set_sel  (widx_q),
      .set_bits (cand),
      .clr_en   ((state_q == ST_FREE) && clr_ok_q),
      .clr_sel  (clr_word_q),
      .clr_bits (clr_bits_q),
      .words    (map_words)
   );

   assign free_idx = req_offset[SIZE_W-1:BLK_LG];
   assign free_hi  = free_idx[IDX_W-1:POS_W];
   assign busy     = (state_q != ST_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q       <= ST_IDLE;
         widx_q        <= '0;
         pos_q         <= '0;
         step_q        <= '0;
         mask_q        <= '0;
         bad_q         <= 1'b0;
         clr_word_q    <= '0;
         clr_bits_q    <= '0;
         clr_ok_q      <= 1'b0;
         done          <= 1'b0;
         result_offset <= '0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  if (req_free) begin
                     state_q    <= ST_FREE;
                     clr_word_q <= WIDX_W'(free_hi);
                     clr_ok_q   <= free_hi < HI_W'(MAP_WORDS);
                     clr_bits_q <= sz_mask << free_idx[POS_W-1:0];
                  end else begin
                     state_q <= ST_SCAN;
                     widx_q  <= '0;
                     pos_q   <= '0;
                     step_q  <= sz_step;
                     mask_q  <= sz_mask;
                     bad_q   <= !sz_ok;
                  end
               end
            end
            ST_SCAN: begin
               if (bad_q) begin
                  state_q       <= ST_IDLE;
                  done          <= 1'b1;
                  result_offset <= FAIL_CODE;
               end else if (fits) begin
                  state_q       <= ST_IDLE;
                  done          <= 1'b1;
                  result_offset <= SIZE_W'({widx_q, pos_q}) << BLK_LG;
               end else if (wrap) begin
                  if (widx_q == LAST_WORD) begin
                     state_q       <= ST_IDLE;
                     done          <= 1'b1;
                     result_offset <= FAIL_CODE;
                  end else begin
                     widx_q <= widx_q + WIDX_W'(1);
                     pos_q  <= '0;
                  end
               end else begin
                  pos_q <= next_pos;
               end
            end
            ST_FREE: begin
               state_q       <= ST_IDLE;
               done          <= 1'b1;
               result_offset <= '0;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/blkmap_alloc_chk.sv
module blkmap_alloc_chk #(
   parameter int unsigned MEM_BYTES = 16384,
   parameter int unsigned MAP_WORDS = 2,
   parameter int unsigned SIZE_W    = $clog2(MEM_BYTES) + 1
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic              req_free,
   input logic [SIZE_W-1:0] req_size,
   input logic [SIZE_W-1:0] req_offset,
   input logic              busy,
   input logic              done,
   input logic [SIZE_W-1:0] result_offset
);
   localparam int unsigned BLK = MEM_BYTES / (32 * MAP_WORDS);

   AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !busy) |=> busy); // R10
   AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (rst)
      done |-> $past(busy)); // R10
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy); // R10
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R10
   AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> done); // R11
   AST_RESULT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      done |-> (result_offset % SIZE_W'(BLK)) == '0); // R2
   AST_RESULT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      done |-> result_offset <= SIZE_W'(MEM_BYTES)); // R8

endmodule

bind blkmap_alloc blkmap_alloc_chk #(
   .MEM_BYTES (MEM_BYTES),
   .MAP_WORDS (MAP_WORDS),
   .SIZE_W    (SIZE_W)
) u_chk (.*);

// File: tb/sim_blkmap_alloc.sv
module sim_blkmap_alloc;
   localparam int MEM   = 16384;
   localparam int WORDS = 2;
   localparam int SW    = 15;
   localparam int BLK   = MEM / (32 * WORDS);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req_valid = 1'b0;
   logic          req_free = 1'b0;
   logic [SW-1:0] req_size = '0;
   logic [SW-1:0] req_offset = '0;
   logic          busy;
   logic          done;
   logic [SW-1:0] result_offset;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit mdl [WORDS*32];
   int q_off[$];
   int q_size[$];

   always #4 clk = ~clk;

   blkmap_alloc #(.MEM_BYTES(MEM), .MAP_WORDS(WORDS), .SIZE_W(SW)) u0 (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_free(req_free),
      .req_size(req_size), .req_offset(req_offset),
      .busy(busy), .done(done), .result_offset(result_offset));

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic model_alloc(input int size, output int off, output int n);
      int blocks, step;
      bit hit;
      off = MEM;
      n = 1;
      if (size == 0) return;
      blocks = (size + BLK - 1) / BLK;
      if (blocks > 32) return;
      step = 1;
      while (step < blocks) step = step * 2;
      n = 0;
      for (int w = 0; w < WORDS; w++) begin
         for (int p = 0; p < 32; p += step) begin
            n++;
            hit = 1'b1;
            for (int k = p; k < p + blocks; k++)
               if (mdl[w*32+k]) hit = 1'b0;
            if (hit) begin
               for (int k = p; k < p + blocks; k++) mdl[w*32+k] = 1'b1;
               off = (w * 32 + p) * BLK;
               return;
            end
         end
      end
   endtask

   task automatic model_free(input int off, input int size);
      int blocks, idx, w, b;
      blocks = (size + BLK - 1) / BLK;
      if (blocks > 32) blocks = 32;
      idx = off / BLK;
      w = idx / 32;
      b = idx % 32;
      if (w < WORDS)
         for (int k = b; k < 32 && k < b + blocks; k++) mdl[w*32+k] = 1'b0;
   endtask

   // One request, compared on every clock from the idle cycle to done.
   task automatic run_req(input bit fr, input int size, input int offs,
                          input bit spur, input int exp_off_in, input string tag,
                          output int got);
      int exp_off, n;
      if (fr) begin
         model_free(offs, size);
         exp_off = 0;
         n = 1;
      end else begin
         model_alloc(size, exp_off, n);
      end
      if (exp_off_in >= 0)
         chk(exp_off == exp_off_in, tag, "model vs plan", exp_off, exp_off_in);
      @(negedge clk);
      chk(!busy && !done, tag, "idle before request", {busy, done}, 0);
      req_valid = 1'b1;
      req_free = fr;
      req_size = SW'(size);
      req_offset = SW'(offs);
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < n; i++) begin
         chk(busy && !done, tag, "busy during work", {busy, done}, 2);
         if (spur && i == 0) begin
            req_valid = 1'b1;
            req_free = 1'b0;
            req_size = SW'(BLK);
         end
         @(negedge clk);
         req_valid = 1'b0;
      end
      chk(!busy && done, tag, "done pulse", {busy, done}, 1);
      chk(int'(result_offset) == exp_off, tag, "result", int'(result_offset), exp_off);
      got = int'(result_offset);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            $display("FAIL R10 watchdog: actual %0d cycles expected below %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      int got, sz, pick;
      repeat (3) @(negedge clk);
      chk(!busy && !done, "R1", "reset outputs", {busy, done}, 0);
      rst = 1'b0;
      // R1 R2: empty map, first block
      run_req(0, 256, 0, 0, 0, "R1", got);
      // R3: two blocks, stride 2 skips bit 1
      run_req(0, 300, 0, 0, 512, "R3", got);
      // R4: single block takes first hole at bit 1
      run_req(0, 100, 0, 0, 256, "R4", got);
      // R6 zero size; R7 oversize
      run_req(0, 0, 0, 0, MEM, "R6", got);
      run_req(0, 8193, 0, 1, MEM, "R7", got);
      // R5: whole-word run moves to word 1
      run_req(0, 8192, 0, 0, 8192, "R5", got);
      // R3: half-word run lands at bit 16
      run_req(0, 4096, 0, 0, 4096, "R3", got);
      // R8: no free candidate anywhere (4 probes)
      run_req(0, 4096, 0, 1, MEM, "R8", got);
      // R9: release word 1 then reuse it
      run_req(1, 8192, 8192, 0, 0, "R9", got);
      run_req(0, 4096, 0, 0, 8192, "R9", got);
      // R9: free past bit 31 is cut at the word edge
      run_req(1, 8192, 16 * BLK, 0, 0, "R9", got);
      run_req(0, 4096, 0, 0, 4096, "R9", got);
      // R11: mixed traffic, latency compared each clock
      run_req(1, 8192, 0, 0, 0, "R11", got);
      run_req(1, 8192, 8192, 0, 0, "R11", got);
      for (int i = 0; i < 400; i++) begin
         if (q_off.size() > 0 && $urandom_range(0, 9) < 4) begin
            pick = $urandom_range(0, q_off.size() - 1);
            run_req(1, q_size[pick], q_off[pick], 0, -1, "R11", got);
            q_off.delete(pick);
            q_size.delete(pick);
         end else begin
            sz = $urandom_range(1, 5 * BLK);
            if ($urandom_range(0, 7) == 0) sz = $urandom_range(1, 32) * BLK;
            run_req(0, sz, 0, (i % 5) == 0, -1, "R11", got);
            if (got != MEM) begin
               q_off.push_back(got);
               q_size.push_back(sz);
            end
         end
      end
      @(negedge clk);
      chk(!busy && !done, "R10", "idle at end", {busy, done}, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule